// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the 16-bit status word of a small minicomputer-style CPU. The word packs four condition flags, a trace flag, an interrupt priority field, a register-bank select and two mode fields. Three independent sources can update it. The instruction sequencer commits new condition flags once an instruction's destination write is done. The memory bus can store into the word at its mapped address. A privileged full load replaces the whole word when a trap handler returns.

The register settles which source wins in every cycle. A full load always wins. An address abort on the current destination write discards both the bus store and the flag commit, so the word keeps its value. A bus store to the word beats the flag commit of the instruction that performed it, so the flags carried in the stored data are the ones kept. A bus store cannot change the trace flag. Three bits that have no function always read as zero.

Top module: `cpu_status_word`

## Requirements
- R1: While reset (`rst_n` low) is applied, `stat_q` reads 16'h0000.
- R2: A flag commit with no abort, no bus store and no load sets each flag bit whose enable in `flg_we` is 1 to the matching bit of `flg_new`, and leaves every flag with enable 0 and every bit from 4 up unchanged. The flag positions are C = bit 0, V = bit 1, Z = bit 2 and N = bit 3.
- R3: A move-style commit (enables N, Z, V = 1, C enable = 0, new V = 0) sets N and Z from the moved value, clears V and keeps the previous C.
- R4: A clear-style commit (all four enables = 1, new flags N=0 Z=1 V=0 C=0) gives flags 4'b0100 whatever their previous value.
- R5: A sign-extend-style commit (enables Z and V = 1, N and C = 0, new V = 0) sets Z from the result, clears V and keeps both N and C.
- R6: A bus store with no abort and no load writes the flags (bits 3:0), the priority (bits 7:5), the register-bank select (bit 11), the previous mode (bits 13:12) and the current mode (bits 15:14) from `bus_wdata`.
- R7: A bus store never changes the trace flag (bit 4). Storing 16'h0010 into a zero word reads back 16'h0000.
- R8: Bits 10:8 read as zero at all times, whatever a bus store or a full load writes.
- R9: When a bus store and a flag commit happen in the same cycle with no abort, bits 3:0 take the bus data and the flag commit is discarded.
- R10: In a cycle with `abort` high and no full load, the whole word keeps its value even when a bus store or a flag commit is also requested.
- R11: A full load sets every bit except 10:8 from `load_data`, the trace flag included. It takes priority over a bus store, a flag commit and an abort in the same cycle.
- R12: In a cycle with no load, bus store or flag enable, the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the word |
| flg_we | input | 4 | Per-flag commit enables {N,Z,V,C} |
| flg_new | input | 4 | New flag values {N,Z,V,C} |
| bus_we | input | 1 | Bus store strobe to the status word address |
| bus_wdata | input | 16 | Bus store data |
| load_we | input | 1 | Privileged full-load strobe (trap return) |
| load_data | input | 16 | Full-load data |
| abort | input | 1 | Address error on the current destination write |
| stat_q | output | 16 | Current status word |

## Verification
The hardest situation to produce is the collision in one cycle of an abort, a bus store, a flag commit and a full load, because each rule alone hides how the others are ranked. The bench sweeps all sixteen combinations of those four strobes from one known preloaded word. It uses distinct data on every source, so the value that appears shows which source won. Before each case it sets the word to a fixed value through the full-load port. This makes "unchanged" a value that the ports can see, not an assumption.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_FLG  = 2'd1,
      SRC_BUS  = 2'd2,
      SRC_LOAD = 2'd3
   } csw_src_e;
endpackage

// File: rtl/csw_mask_gen.sv
`timescale 1ns/1ps
module csw_mask_gen #(
   parameter int WORD_W        = 16,
   parameter int T_POS         = 4,
   parameter int DEAD_LSB      = 8,
   parameter int DEAD_MSB      = 10,
   parameter bit LOAD_WRITES_T = 1'b1
) (
   output logic [WORD_W-1:0] bus_mask,
   output logic [WORD_W-1:0] load_mask,
   output logic [WORD_W-1:0] live_mask
);
   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam bit DEAD = (i >= DEAD_LSB) && (i <= DEAD_MSB);
      localparam bit IS_T = (i == T_POS);
      assign live_mask[i] = !DEAD;
      assign bus_mask[i]  = !DEAD && !IS_T;
      if (IS_T) begin : g_t
         assign load_mask[i] = LOAD_WRITES_T;
      end else begin : g_n
         assign load_mask[i] = !DEAD;
      end
   end
endmodule

// File: rtl/csw_flag_merge.sv
`timescale 1ns/1ps
module csw_flag_merge #(
   parameter int FLG_W = 4
) (
   input  logic [FLG_W-1:0] flg_cur,
   input  logic [FLG_W-1:0] flg_we,
   input  logic [FLG_W-1:0] flg_new,
   output logic [FLG_W-1:0] flg_nxt
);
   for (genvar i = 0; i < FLG_W; i++) begin : g_flg
      assign flg_nxt[i] = flg_we[i] ? flg_new[i] : flg_cur[i];
   end
endmodule

// File: rtl/csw_arbiter.sv
`timescale 1ns/1ps
module csw_arbiter
   import csw_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int FLG_W  = 4
) (
   input  logic [WORD_W-1:0] cur,
   input  logic              load_we,
   input  logic [WORD_W-1:0] load_data,
   input  logic [WORD_W-1:0] load_mask,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic [WORD_W-1:0] bus_mask,
   input  logic [WORD_W-1:0] live_mask,
   input  logic              flg_any,
   input  logic [FLG_W-1:0]  flg_nxt,
   input  logic              abort,
   output csw_src_e          src,
   output logic [WORD_W-1:0] nxt
);
   always_comb begin
      if (load_we)      src = SRC_LOAD;
      else if (abort)   src = SRC_HOLD;
      else if (bus_we)  src = SRC_BUS;
      else if (flg_any) src = SRC_FLG;
      else              src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_LOAD: nxt = ((load_data & load_mask) | (cur & ~load_mask)) & live_mask;
         SRC_BUS:  nxt = ((bus_wdata & bus_mask) | (cur & ~bus_mask)) & live_mask;
         SRC_FLG:  nxt = {cur[WORD_W-1:FLG_W], flg_nxt};
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/cpu_status_word.sv
`timescale 1ns/1ps
module cpu_status_word
   import csw_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int FLG_W         = 4,
   parameter int T_POS         = 4,
   parameter int DEAD_LSB      = 8,
   parameter int DEAD_MSB      = 10,
   parameter bit LOAD_WRITES_T = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLG_W-1:0]  flg_we,
   input  logic [FLG_W-1:0]  flg_new,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              load_we,
   input  logic [WORD_W-1:0] load_data,
   input  logic              abort,
   output logic [WORD_W-1:0] stat_q
);
   localparam int DEAD_N = DEAD_MSB - DEAD_LSB + 1;

   if (T_POS < FLG_W || T_POS >= WORD_W) begin : g_bad_t
      $error("trace flag position must lie above the flags and inside the word");
   end
   if (DEAD_N < 1 || DEAD_MSB >= WORD_W || DEAD_LSB <= T_POS) begin : g_bad_dead
      $error("unused field must be non-empty, inside the word and above the trace flag");
   end

   logic [WORD_W-1:0] bus_mask, load_mask, live_mask, nxt, q;
   logic [FLG_W-1:0]  flg_nxt;
   csw_src_e          src;

   csw_mask_gen #(
      .WORD_W(WORD_W), .T_POS(T_POS), .DEAD_LSB(DEAD_LSB),
      .DEAD_MSB(DEAD_MSB), .LOAD_WRITES_T(LOAD_WRITES_T)
   ) u_mask (
      .bus_mask(bus_mask), .load_mask(load_mask), .live_mask(live_mask)
   );

   csw_flag_merge #(.FLG_W(FLG_W)) u_merge (
      .flg_cur(q[FLG_W-1:0]), .flg_we(flg_we), .flg_new(flg_new), .flg_nxt(flg_nxt)
   );

   csw_arbiter #(.WORD_W(WORD_W), .FLG_W(FLG_W)) u_arb (
      .cur(q), .load_we(load_we), .load_data(load_data), .load_mask(load_mask),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_mask(bus_mask),
      .live_mask(live_mask), .flg_any(|flg_we), .flg_nxt(flg_nxt),
      .abort(abort), .src(src), .nxt(nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   assign stat_q = q;
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker #(
   parameter int WORD_W   = 16,
   parameter int FLG_W    = 4,
   parameter int T_POS    = 4,
   parameter int DEAD_LSB = 8,
   parameter int DEAD_MSB = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FLG_W-1:0]  flg_we,
   input logic [FLG_W-1:0]  flg_new,
   input logic              bus_we,
   input logic [WORD_W-1:0] bus_wdata,
   input logic              load_we,
   input logic [WORD_W-1:0] load_data,
   input logic              abort,
   input logic [WORD_W-1:0] stat_q
);
   // R8
   dead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[DEAD_MSB:DEAD_LSB] == '0);

   // R7
   tbit_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !load_we && !abort) |=> stat_q[T_POS] == $past(stat_q[T_POS]));

   // R9
   bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !load_we && !abort) |=> stat_q[FLG_W-1:0] == $past(bus_wdata[FLG_W-1:0]));

   // R10
   abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !load_we) |=> $stable(stat_q));

   // R2
   flg_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !load_we && !abort) |=>
         (stat_q[FLG_W-1:0] == (($past(flg_new) & $past(flg_we)) |
                               ($past(stat_q[FLG_W-1:0]) & ~$past(flg_we)))) &&
         (stat_q[WORD_W-1:FLG_W] == $past(stat_q[WORD_W-1:FLG_W])));

   // R11
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> stat_q[T_POS] == $past(load_data[T_POS]) &&
                  stat_q[WORD_W-1:DEAD_MSB+1] == $past(load_data[WORD_W-1:DEAD_MSB+1]));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !load_we && flg_we == '0) |=> $stable(stat_q));
endmodule

bind cpu_status_word csw_checker #(
   .WORD_W(WORD_W), .FLG_W(FLG_W), .T_POS(T_POS),
   .DEAD_LSB(DEAD_LSB), .DEAD_MSB(DEAD_MSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flg_we(flg_we), .flg_new(flg_new),
   .bus_we(bus_we), .bus_wdata(bus_wdata), .load_we(load_we),
   .load_data(load_data), .abort(abort), .stat_q(stat_q)
);

// File: tb/sim_cpu_status_word.sv
`timescale 1ns/1ps
module sim_cpu_status_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flg_we = '0, flg_new = '0;
   logic        bus_we = 1'b0, load_we = 1'b0, abort = 1'b0;
   logic [15:0] bus_wdata = '0, load_data = '0;
   logic [15:0] stat_q;

   int n_chk = 0, n_err = 0;
   logic [15:0] exp_q = '0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cpu_status_word u0 (
      .clk(clk), .rst_n(rst_n), .flg_we(flg_we), .flg_new(flg_new),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .load_we(load_we),
      .load_data(load_data), .abort(abort), .stat_q(stat_q)
   );

   function automatic logic [15:0] model(input logic [15:0] q, input logic ld,
      input logic [15:0] ldd, input logic bw, input logic [15:0] bd,
      input logic [3:0] cw, input logic [3:0] cn, input logic ab);
      if (ld) return ldd & 16'hF8FF;
      if (ab) return q;
      if (bw) return (bd & 16'hF8EF) | (q & 16'h0010);
      return {q[15:4], (cn & cw) | (q[3:0] & ~cw)};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic ld, input logic [15:0] ldd, input logic bw,
      input logic [15:0] bd, input logic [3:0] cw, input logic [3:0] cn,
      input logic ab, input string tag);
      @(negedge clk);
      load_we = ld; load_data = ldd; bus_we = bw; bus_wdata = bd;
      flg_we = cw; flg_new = cn; abort = ab;
      exp_q = model(exp_q, ld, ldd, bw, bd, cw, cn, ab);
      @(posedge clk);
      #1;
      check(tag, stat_q, exp_q);
      load_we = 1'b0; bus_we = 1'b0; flg_we = '0; abort = 1'b0;
   endtask

   task automatic preload(input logic [15:0] v);
      cyc(1'b1, v, 1'b0, 16'h0, 4'h0, 4'h0, 1'b0, "R11 preload");
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R1: reset state, also with strobes active
      bus_we = 1'b1; bus_wdata = 16'hFFFF; load_we = 1'b1; load_data = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1 check("R1 reset", stat_q, 16'h0000);
      @(negedge clk);
      bus_we = 1'b0; load_we = 1'b0;
      rst_n = 1'b1;
      exp_q = '0;

      // R2: exhaustive enables x new values from two base words
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 16; w++)
            for (int n = 0; n < 16; n++) begin
               preload(b ? 16'hF8EA : 16'h0015);
               cyc(1'b0, 16'h0, 1'b0, 16'h0, w[3:0], n[3:0], 1'b0, "R2 flag merge");
            end

      // R3: move-style commit, N Z from value, V cleared, C kept
      for (int c = 0; c < 2; c++)
         for (int k = 0; k < 3; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0123 : 16'h8000;
            preload(16'h000E | 16'(c));
            cyc(1'b0, 16'h0, 1'b0, 16'h0, 4'b1110, {v[15], v == 16'h0, 1'b0, 1'b0}, 1'b0, "R3 move");
            check("R3 carry kept", {15'h0, stat_q[0]}, 16'(c));
         end

      // R4: clear-style commit from every flag state
      for (int f = 0; f < 16; f++) begin
         preload(16'h00E0 | 16'(f));
         cyc(1'b0, 16'h0, 1'b0, 16'h0, 4'b1111, 4'b0100, 1'b0, "R4 clear");
         check("R4 flags", {12'h0, stat_q[3:0]}, 16'h0004);
      end

      // R5: sign-extend-style commit keeps N and C
      for (int f = 0; f < 16; f++)
         for (int z = 0; z < 2; z++) begin
            preload(16'(f));
            cyc(1'b0, 16'h0, 1'b0, 16'h0, 4'b0110, {1'b0, z[0], 2'b00}, 1'b0, "R5 sext");
            check("R5 flags", {12'h0, stat_q[3:0]}, {12'h0, f[3], z[0], 1'b0, f[0]});
         end

      // R6 R7 R8: walking-one bus stores from a zero word
      for (int i = 0; i < 16; i++) begin
         preload(16'h0000);
         cyc(1'b0, 16'h0, 1'b1, 16'h1 << i, 4'h0, 4'h0, 1'b0,
             (i == 4) ? "R7 tbit bus" : (i >= 8 && i <= 10) ? "R8 dead bits" : "R6 bus store");
      end
      preload(16'h0000);
      cyc(1'b0, 16'h0, 1'b1, 16'hFFFF, 4'h0, 4'h0, 1'b0, "R6 bus all ones");
      check("R6 value", stat_q, 16'hF8EF);
      cyc(1'b0, 16'h0, 1'b1, 16'h5A5A, 4'h0, 4'h0, 1'b0, "R6 bus pattern");
      preload(16'h0010);
      cyc(1'b0, 16'h0, 1'b1, 16'h0000, 4'h0, 4'h0, 1'b0, "R7 tbit survives");
      check("R7 value", stat_q, 16'h0010);

      // R8 R11: full load writes trace, never dead bits
      cyc(1'b1, 16'hFFFF, 1'b0, 16'h0, 4'h0, 4'h0, 1'b0, "R8 load dead bits");
      check("R11 load value", stat_q, 16'hF8FF);
      cyc(1'b1, 16'h0010, 1'b0, 16'h0, 4'h0, 4'h0, 1'b0, "R11 load tbit");

      // R9: bus store beats every flag commit
      for (int w = 0; w < 16; w++) begin
         preload(16'h000F);
         cyc(1'b0, 16'h0, 1'b1, 16'h3005 ^ 16'(w), w[3:0], ~w[3:0], 1'b0, "R9 bus over flags");
      end

      // R10 R11: all strobe collisions from a known word
      for (int m = 0; m < 16; m++) begin
         preload(16'h2A05);
         cyc(m[3], 16'hC0F2, m[2], 16'h30A9, m[1] ? 4'hF : 4'h0, 4'hA, m[0],
             m[3] ? "R11 load priority" : m[0] ? "R10 abort hold" :
             m[2] ? "R9 collision" : "R2 collision");
      end

      // R12: idle cycles hold
      preload(16'hC8E9);
      for (int i = 0; i < 4; i++)
         cyc(1'b0, 16'h1234, 1'b0, 16'h5678, 4'h0, 4'hF, 1'b0, "R12 idle hold");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule